// File: doc/BRIEF.md
# Mux-D Scan Chain Test Sequencer

This block is a chain of multiplexed-data scan cells wrapped around a small combinational core, plus a sequencer that runs structural tests on that core. In functional mode every cell loads the core output on each clock. Cell `i` takes the XOR of cell `i-1` and primary input bit `i`, and cell 0 takes its left-hand term from cell `N-1`. In test mode the sequencer raises test enable, which turns the cells into a shift register running from a serial source toward `scan_out`.

A pulse on `start` begins a test run. The run opens with a built-in chain-integrity test. The sequencer first shifts zeros to clear the chain. It then shifts a single one, then an alternating stream, and compares `scan_out` against the stream delayed by exactly the chain length.

For each pattern the sequencer then:
- asks the external tester for `N` serial bits;
- drops test enable and holds the chain for a programmable number of settle cycles;
- drops test enable for a single capture clock.

The response of a pattern is shifted out while the next pattern is shifted in. After the last capture, one more unload runs with zeros fed in, and then the run stops in a done state.

Top module: `scan_chain_ctrl`

## Requirements
- R1: After synchronous reset all cells hold 0, and `test_en`, `shift_req`, `unload_vld`, `done` and `flush_err` are all 0.
- R2: In the idle (functional) state, each clock loads cell `i` with `q[(i-1) mod N] ^ pi[i]`. Bit positions count from 0 at the scan-in end of the chain.
- R3: With `test_en` low in the idle state, `func_clr` clears every cell on the next clock. While `test_en` is high, `func_clr` has no effect on the chain.
- R4: While `test_en` is high, cell `i` loads cell `i-1` and cell 0 loads the serial source; `scan_out` is always cell `N-1`.
- R5: The cycle after `start` is sampled in idle or done, a flush of `4N` cycles begins with `test_en` high and `shift_req` low. The stream is fed internally, in this order: `N` zeros, a single 1, `N-1` zeros, then `2N` bits alternating and starting with 1. At flush cycle `t >= N`, `scan_out` equals stream bit `t-N`. Any mismatch sets `flush_err` and ends the run in done.
- R6: Each pattern load holds `shift_req` and `test_en` high for `N` cycles. The bit taken from `scan_in` in load cycle `k` ends up in cell `N-1-k`.
- R7: After a load, `test_en` stays low and the chain holds its value for `settle_cycles` cycles; a value of 0 skips the settle phase.
- R8: One capture cycle follows with `test_en` low. In that cycle the cells load the core function of the loaded pattern and `pi`.
- R9: The response of pattern `k` leaves on `scan_out`, cell `N-1` first, during the load of pattern `k+1`, with `unload_vld` high.
- R10: After the last capture, a final unload of `N` cycles runs with `test_en` and `unload_vld` high, `shift_req` low and zeros fed in. Then `done` rises, test enable stays low and the chain holds (all zero).
- R11: When `num_pat` is 0, `done` rises right after the flush, with no load.
- R12: A `start` pulse in the done state begins a new run with fresh `num_pat` and `settle_cycles` and a cleared `flush_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a test run when idle or done |
| num_pat | input | PAT_W | Number of patterns in the run |
| settle_cycles | input | SET_W | Hold cycles between load and capture |
| pi | input | CHAIN_LEN | Primary inputs to the core |
| func_clr | input | 1 | Functional synchronous clear, blocked in scan mode |
| scan_in | input | 1 | Serial pattern data from the tester |
| test_en | output | 1 | Scan enable to all cells |
| shift_req | output | 1 | `scan_in` is taken at the next edge |
| unload_vld | output | 1 | `scan_out` carries a response bit |
| scan_out | output | 1 | Last cell of the chain |
| core_q | output | CHAIN_LEN | Cell outputs (primary outputs of the core) |
| done | output | 1 | Run finished |
| flush_err | output | 1 | Chain-integrity test saw a wrong bit |

## Verification
A broken link between cells or a wrong serial source shows up in the flush. The expected bit goes missing on `scan_out` exactly `N` cycles after it was fed in, well before any pattern runs. A sequencer counter that is off by one shifts every response bit by a position, so the scoreboard catches it in the first unload. The same error also changes the count of low `test_en` cycles between load and capture. A clear that leaks into scan mode, or a capture taken during settle, corrupts the very next response popped from the queue.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_SHIFT,
        ST_SETTLE,
        ST_CAPTURE,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_FLUSH,
        SRC_PIN,
        SRC_ZERO
    } serial_src_e;

    typedef struct packed {
        logic        ce;
        logic        te;
        serial_src_e src;
    } cell_ctl_t;

    // integrity stream: n zeros, a lone one, n-1 zeros, then alternating from 1
    function automatic logic flush_bit(input int unsigned t, input int unsigned n);
        if (t < n)
            return 1'b0;
        else if (t == n)
            return 1'b1;
        else if (t < 2 * n)
            return 1'b0;
        else
            return ~t[0];
    endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic te,
    input  logic clr,
    input  logic d,
    input  logic si,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ce) begin
            if (te)
                q <= si;
            else if (clr)
                q <= 1'b0;
            else
                q <= d;
        end
    end
endmodule

// File: rtl/scan_core.sv
module scan_core #(
    parameter int N = 8
) (
    input  logic [N-1:0] q,
    input  logic [N-1:0] pi,
    output logic [N-1:0] nxt
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_wrap
            assign nxt[i] = q[N-1] ^ pi[i];
        end else begin : g_link
            assign nxt[i] = q[i-1] ^ pi[i];
        end
    end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int PAT_W     = 4,
    parameter int SET_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PAT_W-1:0] num_pat,
    input  logic [SET_W-1:0] settle_cycles,
    input  logic             chain_tail,
    output cell_ctl_t        ctl,
    output logic             gen_bit,
    output logic             shift_req,
    output logic             unload_vld,
    output logic             done,
    output logic             flush_err,
    output seq_state_e       state_o
);
    localparam int FLUSH_LEN = 4 * CHAIN_LEN;
    localparam int CNT_W     = $clog2(FLUSH_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_FLUSH = CNT_W'(FLUSH_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(CHAIN_LEN - 1);
    localparam logic [CNT_W-1:0] LEN_C      = CNT_W'(CHAIN_LEN);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [SET_W-1:0] scnt;
    logic [PAT_W-1:0] pcnt, npat_q;
    logic [SET_W-1:0] settle_q;
    logic             last_q, err_q;
    logic             mism, err_n;
    logic [PAT_W-1:0] pcnt_n;

    assign pcnt_n = pcnt + PAT_W'(1);

    always_comb begin
        mism = 1'b0;
        if (state == ST_FLUSH && cnt >= LEN_C)
            mism = (chain_tail != flush_bit(32'(cnt - LEN_C), CHAIN_LEN));
        err_n = err_q | mism;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            scnt     <= '0;
            pcnt     <= '0;
            npat_q   <= '0;
            settle_q <= '0;
            last_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state    <= ST_FLUSH;
                        cnt      <= '0;
                        pcnt     <= '0;
                        last_q   <= 1'b0;
                        err_q    <= 1'b0;
                        npat_q   <= num_pat;
                        settle_q <= settle_cycles;
                    end
                end
                ST_FLUSH: begin
                    err_q <= err_n;
                    if (cnt == LAST_FLUSH) begin
                        cnt <= '0;
                        if (err_n || npat_q == '0)
                            state <= ST_DONE;
                        else
                            state <= ST_SHIFT;
                    end else
                        cnt <= cnt + CNT_W'(1);
                end
                ST_SHIFT: begin
                    if (cnt == LAST_SHIFT) begin
                        cnt  <= '0;
                        scnt <= '0;
                        if (last_q)
                            state <= ST_DONE;
                        else if (settle_q == '0)
                            state <= ST_CAPTURE;
                        else
                            state <= ST_SETTLE;
                    end else
                        cnt <= cnt + CNT_W'(1);
                end
                ST_SETTLE: begin
                    if (scnt == settle_q - SET_W'(1))
                        state <= ST_CAPTURE;
                    else
                        scnt <= scnt + SET_W'(1);
                end
                ST_CAPTURE: begin
                    pcnt   <= pcnt_n;
                    last_q <= (pcnt_n == npat_q);
                    state  <= ST_SHIFT;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl = '{ce: 1'b0, te: 1'b0, src: SRC_ZERO};
        case (state)
            ST_IDLE:    ctl = '{ce: 1'b1, te: 1'b0, src: SRC_ZERO};
            ST_FLUSH:   ctl = '{ce: 1'b1, te: 1'b1, src: SRC_FLUSH};
            ST_SHIFT:   ctl = '{ce: 1'b1, te: 1'b1, src: (last_q ? SRC_ZERO : SRC_PIN)};
            ST_CAPTURE: ctl = '{ce: 1'b1, te: 1'b0, src: SRC_ZERO};
            default:    ctl = '{ce: 1'b0, te: 1'b0, src: SRC_ZERO};
        endcase
    end

    assign gen_bit    = flush_bit(32'(cnt), CHAIN_LEN);
    assign shift_req  = (state == ST_SHIFT) && !last_q;
    assign unload_vld = (state == ST_SHIFT) && (pcnt != '0);
    assign done       = (state == ST_DONE);
    assign flush_err  = err_q;
    assign state_o    = state;
endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
    import scan_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int PAT_W     = 4,
    parameter int SET_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [PAT_W-1:0]     num_pat,
    input  logic [SET_W-1:0]     settle_cycles,
    input  logic [CHAIN_LEN-1:0] pi,
    input  logic                 func_clr,
    input  logic                 scan_in,
    output logic                 test_en,
    output logic                 shift_req,
    output logic                 unload_vld,
    output logic                 scan_out,
    output logic [CHAIN_LEN-1:0] core_q,
    output logic                 done,
    output logic                 flush_err
);
    cell_ctl_t            ctl;
    seq_state_e           seq_state;
    logic                 gen_bit;
    logic                 chain_si;
    logic [CHAIN_LEN-1:0] q, nxt;

    scan_seq #(
        .CHAIN_LEN(CHAIN_LEN),
        .PAT_W    (PAT_W),
        .SET_W    (SET_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .num_pat      (num_pat),
        .settle_cycles(settle_cycles),
        .chain_tail   (q[CHAIN_LEN-1]),
        .ctl          (ctl),
        .gen_bit      (gen_bit),
        .shift_req    (shift_req),
        .unload_vld   (unload_vld),
        .done         (done),
        .flush_err    (flush_err),
        .state_o      (seq_state)
    );

    always_comb begin
        case (ctl.src)
            SRC_FLUSH: chain_si = gen_bit;
            SRC_PIN:   chain_si = scan_in;
            default:   chain_si = 1'b0;
        endcase
    end

    scan_core #(.N(CHAIN_LEN)) u_core (
        .q  (q),
        .pi (pi),
        .nxt(nxt)
    );

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        logic link;
        if (i == 0) begin : g_head
            assign link = chain_si;
        end else begin : g_body
            assign link = q[i-1];
        end
        scan_cell u_cell (
            .clk(clk),
            .rst(rst),
            .ce (ctl.ce),
            .te (ctl.te),
            .clr(func_clr),
            .d  (nxt[i]),
            .si (link),
            .q  (q[i])
        );
    end

    assign test_en  = ctl.te;
    assign scan_out = q[CHAIN_LEN-1];
    assign core_q   = q;
endmodule

// File: rtl/scan_chain_ctrl_chk.sv
module scan_chain_ctrl_chk
    import scan_pkg::*;
#(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         test_en,
    input logic         shift_req,
    input logic         unload_vld,
    input logic         done,
    input logic         scan_out,
    input logic         func_clr,
    input logic [N-1:0] core_q,
    input seq_state_e   state
);
    a_r4_shift_moves: assert property (@(posedge clk) disable iff (rst)
        test_en |=> scan_out == $past(core_q[N-2]));

    a_r3_func_clear: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && func_clr) |=> core_q == '0);

    a_r7_settle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE) |=> $stable(core_q));

    a_r6_req_in_scan: assert property (@(posedge clk) disable iff (rst)
        shift_req |-> test_en);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!test_en && !shift_req && !unload_vld));

    a_r10_done_hold: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(core_q));
endmodule

bind scan_chain_ctrl scan_chain_ctrl_chk #(.N(CHAIN_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .test_en   (test_en),
    .shift_req (shift_req),
    .unload_vld(unload_vld),
    .done      (done),
    .scan_out  (scan_out),
    .func_clr  (func_clr),
    .core_q    (core_q),
    .state     (seq_state)
);

// File: tb/test_scan_chain_ctrl.sv
`timescale 1ns/1ps
module test_scan_chain_ctrl;
    localparam int N = 8;
    localparam int PW = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [PW-1:0] num_pat = '0;
    logic [SW-1:0] settle_cycles = '0;
    logic [N-1:0]  pi = '0;
    logic          func_clr = 1'b0;
    logic          scan_in = 1'b0;
    logic          test_en, shift_req, unload_vld, scan_out, done, flush_err;
    logic [N-1:0]  core_q;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic exp_q[$];
    logic [N-1:0] model;

    always #4 clk = ~clk;

    scan_chain_ctrl #(.CHAIN_LEN(N), .PAT_W(PW), .SET_W(SW)) i_scan_chain_ctrl (
        .clk(clk), .rst(rst), .start(start), .num_pat(num_pat),
        .settle_cycles(settle_cycles), .pi(pi), .func_clr(func_clr),
        .scan_in(scan_in), .test_en(test_en), .shift_req(shift_req),
        .unload_vld(unload_vld), .scan_out(scan_out), .core_q(core_q),
        .done(done), .flush_err(flush_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] core_fn(input logic [N-1:0] q, input logic [N-1:0] p);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = q[(i + N - 1) % N] ^ p[i];
        return r;
    endfunction

    function automatic logic stream(input int t);
        if (t < N) return 1'b0;
        if (t == N) return 1'b1;
        if (t < 2 * N) return 1'b0;
        return (t % 2 == 0);
    endfunction

    // scoreboard monitor: R9 / R10 response bits
    always @(negedge clk) begin
        if (!rst && unload_vld) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R9", "unload with empty queue", 32'(scan_out), 32'hx);
            else begin
                logic e;
                e = exp_q.pop_front();
                chk(scan_out == e, "R9", "response bit", 32'(scan_out), 32'(e));
            end
        end
    end

    task automatic run_flush(input int np, input int st);
        num_pat = PW'(np);
        settle_cycles = SW'(st);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 4 * N; t++) begin
            if (!test_en || shift_req)
                chk(1'b0, "R5", "flush control", {30'd0, test_en, shift_req}, 32'h2);
            if (t >= N)
                chk(scan_out == stream(t - N), "R5", "flush scan_out", 32'(scan_out), 32'(stream(t - N)));
            @(negedge clk);
        end
        chk(flush_err == 1'b0, "R5", "flush_err after flush", 32'(flush_err), 32'd0);
    endtask

    task automatic load(input logic [N-1:0] p, input logic [N-1:0] pv,
                        input bit clr, input int st);
        int gap;
        for (int k = 0; k < N; k++) begin
            while (!shift_req) @(negedge clk);
            if (k == 0) pi = pv;
            func_clr = (k == N - 1) ? 1'b0 : clr;
            scan_in = p[N - 1 - k];
            @(negedge clk);
        end
        func_clr = 1'b0;
        begin
            logic [N-1:0] r;
            r = core_fn(p, pv);
            for (int k = 0; k < N; k++) exp_q.push_back(r[N - 1 - k]);
        end
        chk(core_q == p, "R6", "loaded pattern", 32'(core_q), 32'(p));
        gap = 0;
        while (!test_en) begin
            gap++;
            if (gap > 1)
                chk(core_q == p, "R7", "hold during settle", 32'(core_q), 32'(p));
            @(negedge clk);
        end
        chk(gap == st + 1, "R8", "low test_en cycles (settle+capture)", 32'(gap), 32'(st + 1));
    endtask

    task automatic final_unload();
        int c = 0;
        while (!done) begin
            if (test_en && !shift_req && unload_vld) c++;
            else chk(1'b0, "R10", "final unload control", {29'd0, test_en, shift_req, unload_vld}, 32'h5);
            @(negedge clk);
        end
        chk(c == N, "R10", "final unload length", 32'(c), 32'(N));
        chk(exp_q.size() == 0, "R9", "queue drained", 32'(exp_q.size()), 32'd0);
        chk(core_q == '0, "R10", "chain zero at done", 32'(core_q), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk(done && !test_en && core_q == '0, "R10", "done holds", {30'd0, done, test_en}, 32'h2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(core_q == '0, "R1", "chain after reset", 32'(core_q), 32'd0);
        chk({test_en, shift_req, unload_vld, done, flush_err} == 5'b0, "R1", "flags after reset",
            32'({test_en, shift_req, unload_vld, done, flush_err}), 32'd0);

        // R2 functional mode
        model = '0;
        for (int s = 0; s < 5; s++) begin
            pi = N'(8'h35 + s * 8'h4B);
            @(negedge clk);
            model = core_fn(model, pi);
            chk(core_q == model, "R2", "functional step", 32'(core_q), 32'(model));
        end
        // R3 functional clear
        func_clr = 1'b1;
        @(negedge clk);
        func_clr = 1'b0;
        chk(core_q == '0, "R3", "functional clear", 32'(core_q), 32'd0);
        pi = N'(8'h5A);
        @(negedge clk);

        // run 1: three patterns, settle of 3; clear held during second load (R3)
        run_flush(3, 3);
        load(N'(8'hA5), N'(8'h0F), 1'b0, 3);
        load(N'(8'h3C), N'(8'hF0), 1'b1, 3);
        load(N'(8'hFF), N'(8'h81), 1'b0, 3);
        final_unload();
        chk(flush_err == 1'b0, "R5", "no flush error run 1", 32'(flush_err), 32'd0);

        // run 2: R12 restart from done, one pattern, no settle
        run_flush(1, 0);
        load(N'(8'h01), N'(8'h00), 1'b0, 0);
        final_unload();

        // run 3: R11 zero patterns
        run_flush(0, 2);
        chk(done == 1'b1 && !test_en, "R11", "done right after flush", 32'(done), 32'd1);
        chk(flush_err == 1'b0, "R11", "flush_err clear", 32'(flush_err), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule